// File: doc/BRIEF.md
# Gated Peripheral Clock Divider

This block derives a slower peripheral clock from its input clock. The division ratio comes from a small encoded field, and a single enable bit gates the divided clock. A write strobe loads a new field value. The new ratio does not take effect at once. It is held pending and is switched in only at the end of the current output period, so a ratio change never produces a shortened pulse. While the new ratio is pending, two status bits report busy. Software must wait for these bits to clear before it writes again.

The field uses a compact encoding. A value of zero selects the largest ratio. With the wide parameter set, the field grows by one bit, and that top bit adds a fixed divide-by-64 stage in front of the lower five bits. The enable bit reads back on its own output as soon as it is written. Its effect on the clock output is delayed to the next period boundary. The output is always driven from a register.

Top module: `pclk_gate_div`

## Requirements
- R1: After reset the clock output is low, the status word is zero, the enable readback is 0, and the active ratio is 2^W, where W is the field width (5 by default, 6 in wide mode).
- R2: With the field's top bit clear in wide mode, or in the 5-bit mode, a nonzero field value v divides the input clock by v. A value of zero divides by 2^W.
- R3: In wide mode, a field with bit 5 set divides by 64 times the value in bits 4:0. If bits 4:0 are zero, it divides by 64.
- R4: Each output period of N input cycles starts with floor(N/2) high cycles, and the remaining cycles are low. An odd N therefore has a high phase one cycle shorter than its low phase, and N = 1 keeps the output low.
- R5: The active ratio changes only on the last cycle of an output period, which is the terminal count.
- R6: Busy is set on the cycle after an accepted ratio write. It clears with the clock edge at which the pending ratio becomes active. Status bits 3 and 4 both carry busy, and all other status bits are 0.
- R7: A ratio write made while busy is set is ignored. The ratio that was already pending is the one applied.
- R8: The enable readback follows an enable write on the next cycle. The output gate takes the enable value only at a terminal count, so the output is low whenever the gate is closed.
- R9: A ratio write that arrives on a terminal-count cycle while the block is not busy is not applied at that edge. It waits one full period of the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| div_wr_i | input | 1 | Strobe that loads a new ratio field |
| div_data_i | input | FW | Encoded ratio field (5 bits, or 6 in wide mode) |
| en_wr_i | input | 1 | Strobe that loads the enable bit |
| en_data_i | input | 1 | New enable value |
| clk_div_o | output | 1 | Divided, gated clock output |
| en_rb_o | output | 1 | Readback of the enable bit |
| stat_o | output | 8 | Status word, with busy on bits 3 and 4 |

## Verification
Two events can land in the same cycle: a ratio write and the terminal count of the running period. A third case is an enable change made during the high phase. The bench drives the collision by reading its own reference model to find the last cycle of a period, then issuing the write in exactly that cycle. The write must be accepted but not applied, so busy stays set for one more full old-ratio period. The same reference model checks every cycle of the output, busy and readback, for both a wide-mode and a 5-bit instance, while ratios and enables change under them.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int STAT_W    = 8;
  localparam int BUSY_LO   = 3;
  localparam int BUSY_HI   = 4;
  localparam int PRESCALE  = 64;
  localparam int BASE_W    = 5;

  function automatic int field_w(input bit wide);
    return wide ? BASE_W + 1 : BASE_W;
  endfunction

  function automatic int max_ratio(input bit wide);
    return wide ? PRESCALE * ((1 << BASE_W) - 1) : (1 << BASE_W);
  endfunction
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter bit WIDE = 1'b0,
  parameter int FW   = 5,
  parameter int CW   = 6
) (
  input  logic [FW-1:0] field_i,
  output logic [CW-1:0] ratio_o
);
  localparam logic [CW-1:0] TOP_RATIO = CW'(2 ** FW);

  generate
    if (WIDE) begin : g_wide
      logic [FW-2:0] low;
      assign low = field_i[FW-2:0];
      always_comb begin
        if (field_i[FW-1]) begin
          if (low == '0) ratio_o = CW'(clkdiv_pkg::PRESCALE);
          else           ratio_o = CW'(low) << 6;
        end else if (low == '0) begin
          ratio_o = TOP_RATIO;
        end else begin
          ratio_o = CW'(low);
        end
      end
    end else begin : g_narrow
      always_comb begin
        if (field_i == '0) ratio_o = TOP_RATIO;
        else               ratio_o = CW'(field_i);
      end
    end
  endgenerate
endmodule

// File: rtl/clkdiv_update.sv
module clkdiv_update #(
  parameter int FW = 5,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [CW-1:0] ratio_i,
  input  logic          tc_i,
  output logic          busy_o,
  output logic [CW-1:0] act_o,
  output logic [CW-1:0] nxt_o
);
  localparam logic [CW-1:0] RESET_RATIO = CW'(2 ** FW);

  logic          pend;
  logic [CW-1:0] pend_n;
  logic          accept, apply;

  assign accept = wr_i & ~pend;
  assign apply  = tc_i & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      pend_n <= RESET_RATIO;
      act_o  <= RESET_RATIO;
    end else begin
      if (apply) begin
        act_o <= pend_n;
        pend  <= 1'b0;
      end
      if (accept) begin
        pend   <= 1'b1;
        pend_n <= ratio_i;
      end
    end
  end

  assign busy_o = pend;
  assign nxt_o  = apply ? pend_n : act_o;

  // R5: active ratio only moves at a terminal count
  a_r5_ratio_hold: assert property (@(posedge clk) disable iff (rst)
    !tc_i |=> $stable(act_o));
  // R6: pending ratio leaves busy with the switch
  a_r6_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (pend && tc_i) |=> !pend);
  // R7: writes during busy leave the pending ratio untouched
  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (pend && wr_i) |=> $stable(pend_n));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] act_i,
  input  logic [CW-1:0] nxt_i,
  input  logic          en_i,
  output logic          tc_o,
  output logic          clk_o
);
  logic [CW-1:0] cnt, cnt_nxt, half_nxt;
  logic          gate, gate_nxt;

  assign tc_o     = (cnt == act_i - CW'(1));
  assign cnt_nxt  = tc_o ? '0 : cnt + CW'(1);
  assign gate_nxt = tc_o ? en_i : gate;
  assign half_nxt = nxt_i >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      gate  <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      gate  <= gate_nxt;
      clk_o <= gate_nxt & (cnt_nxt < half_nxt);
    end
  end

  // R4: last cycle of a period is always low
  a_r4_low_at_tc: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> !clk_o);
  // R8: gate only changes on a period boundary
  a_r8_gate_hold: assert property (@(posedge clk) disable iff (rst)
    !tc_o |=> $stable(gate));
  // R8: no output pulse while the gate is closed
  a_r8_closed_low: assert property (@(posedge clk) disable iff (rst)
    !gate |-> !clk_o);
endmodule

// File: rtl/pclk_gate_div.sv
module pclk_gate_div #(
  parameter bit WIDE_MODE = 1'b0,
  localparam int FW = clkdiv_pkg::field_w(WIDE_MODE),
  localparam int CW = $clog2(clkdiv_pkg::max_ratio(WIDE_MODE) + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          div_wr_i,
  input  logic [FW-1:0]                 div_data_i,
  input  logic                          en_wr_i,
  input  logic                          en_data_i,
  output logic                          clk_div_o,
  output logic                          en_rb_o,
  output logic [clkdiv_pkg::STAT_W-1:0] stat_o
);
  logic [CW-1:0] ratio, act, nxt;
  logic          busy, tc, en_q;

  clkdiv_decode #(.WIDE(WIDE_MODE), .FW(FW), .CW(CW)) u_dec (
    .field_i (div_data_i),
    .ratio_o (ratio)
  );

  clkdiv_update #(.FW(FW), .CW(CW)) u_upd (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (div_wr_i),
    .ratio_i (ratio),
    .tc_i    (tc),
    .busy_o  (busy),
    .act_o   (act),
    .nxt_o   (nxt)
  );

  clkdiv_core #(.CW(CW)) u_core (
    .clk   (clk),
    .rst   (rst),
    .act_i (act),
    .nxt_i (nxt),
    .en_i  (en_q),
    .tc_o  (tc),
    .clk_o (clk_div_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (en_wr_i) en_q <= en_data_i;
  end

  assign en_rb_o = en_q;

  always_comb begin
    stat_o = '0;
    stat_o[clkdiv_pkg::BUSY_LO] = busy;
    stat_o[clkdiv_pkg::BUSY_HI] = busy;
  end

  // R8: readback follows an enable write one cycle later
  a_r8_readback: assert property (@(posedge clk) disable iff (rst)
    en_wr_i |=> (en_rb_o == $past(en_data_i)));
  // R6: an accepted write raises busy
  a_r6_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (div_wr_i && !busy) |=> stat_o[clkdiv_pkg::BUSY_HI]);
endmodule

// File: tb/tb_pclk_gate_div.sv
module tb_pclk_gate_div;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       wr = 1'b0, ewr = 1'b0, edat = 1'b0;
  logic [5:0] wd = '0;
  logic       o_w [2];
  logic       rb_w [2];
  logic [7:0] st_w [2];

  pclk_gate_div #(.WIDE_MODE(1'b1)) dut (
    .clk(clk), .rst(rst), .div_wr_i(wr), .div_data_i(wd),
    .en_wr_i(ewr), .en_data_i(edat),
    .clk_div_o(o_w[0]), .en_rb_o(rb_w[0]), .stat_o(st_w[0]));

  pclk_gate_div #(.WIDE_MODE(1'b0)) dut5 (
    .clk(clk), .rst(rst), .div_wr_i(wr), .div_data_i(wd[4:0]),
    .en_wr_i(ewr), .en_data_i(edat),
    .clk_div_o(o_w[1]), .en_rb_o(rb_w[1]), .stat_o(st_w[1]));

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  // reference model: index 0 wide, index 1 five-bit
  int m_cnt[2], m_n[2], m_pn[2];
  bit m_busy[2], m_en[2], m_gate[2];

  function automatic int mdec(input int v, input bit w);
    int f;
    f = w ? (v & 63) : (v & 31);
    if (w && (f & 32) != 0) return ((f & 31) == 0) ? 64 : 64 * (f & 31);
    if (f == 0) return w ? 64 : 32;
    return f;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_cnt[i] = 0; m_n[i] = (i == 0) ? 64 : 32; m_pn[i] = m_n[i];
        m_busy[i] = 0; m_en[i] = 0; m_gate[i] = 0;
      end else begin
        bit tc, acc, app;
        tc  = (m_cnt[i] == m_n[i] - 1);
        acc = wr && !m_busy[i];
        app = tc && m_busy[i];
        if (app) begin m_n[i] = m_pn[i]; m_busy[i] = 0; end
        if (acc) begin m_busy[i] = 1; m_pn[i] = mdec(int'(wd), i == 0); end
        m_cnt[i] = tc ? 0 : m_cnt[i] + 1;
        if (tc) m_gate[i] = m_en[i];
        if (ewr) m_en[i] = edat;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2 R3 R4 R5 R6 R7 R8 R9)
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int i = 0; i < 2; i++) begin
        bit eo;
        eo = m_gate[i] && (m_cnt[i] < m_n[i] / 2);
        chk(o_w[i] == eo, "R4 output", int'(o_w[i]), int'(eo));
        chk(st_w[i] == (m_busy[i] ? 8'h18 : 8'h00), "R6 status", int'(st_w[i]),
            m_busy[i] ? 24 : 0);
        chk(rb_w[i] == m_en[i], "R8 readback", int'(rb_w[i]), int'(m_en[i]));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wrdiv(input logic [5:0] v);
    wd = v; wr = 1'b1; @(negedge clk); wr = 1'b0;
  endtask

  task automatic wren(input bit v);
    edat = v; ewr = 1'b1; @(negedge clk); ewr = 1'b0;
  endtask

  // count cycles between two rising edges of the wide output
  task automatic meas(input int expn, input string tag);
    int t;
    bit p;
    p = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (o_w[0] && !p) break;
      p = o_w[0];
    end
    t = 0; p = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      t++;
      if (o_w[0] && !p) break;
      p = o_w[0];
    end
    chk(t == expn, tag, t, expn);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state seen at the ports
    for (int i = 0; i < 2; i++) begin
      chk(o_w[i] == 1'b0, "R1 out", int'(o_w[i]), 0);
      chk(st_w[i] == 8'h00, "R1 status", int'(st_w[i]), 0);
      chk(rb_w[i] == 1'b0, "R1 enable", int'(rb_w[i]), 0);
    end
    wren(1'b1);
    meas(64, "R1 reset ratio");
    // R2 and R7: second write during busy is dropped
    wrdiv(6'd4);
    wrdiv(6'd9);
    idle(80);
    meas(4, "R2 ratio 4");
    // R4: odd and unit ratios
    wrdiv(6'd3); idle(30);
    meas(3, "R4 ratio 3");
    wrdiv(6'd1); idle(12);
    wrdiv(6'd2); idle(12);
    wrdiv(6'd0); idle(140);
    // R3: prescaled ratios in wide mode
    wrdiv(6'h22); idle(200);
    meas(128, "R3 ratio 128");
    wrdiv(6'h20); idle(150);
    meas(64, "R3 prescale zero");
    wrdiv(6'd5); idle(80);
    // R9: write landing on the terminal count
    for (int k = 0; k < 100; k++) begin
      if (m_cnt[0] == m_n[0] - 1 && !m_busy[0]) break;
      @(negedge clk);
    end
    wrdiv(6'd6);
    chk(st_w[0] == 8'h18, "R9 busy held", int'(st_w[0]), 24);
    idle(3);
    chk(st_w[0] == 8'h18, "R9 still busy", int'(st_w[0]), 24);
    idle(20);
    // R8: disable during the high phase, then re-enable
    for (int k = 0; k < 100; k++) begin
      if (o_w[0]) break;
      @(negedge clk);
    end
    wren(1'b0);
    chk(o_w[0] == 1'b1, "R8 high kept", int'(o_w[0]), 1);
    idle(20);
    chk(o_w[0] == 1'b0, "R8 gated off", int'(o_w[0]), 0);
    wren(1'b1); idle(40);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule